// File: doc/BRIEF.md
# Nested Loop End-Point Flag Generator

This block walks a schedule of up to three nested loops. The innermost loop is x, the middle loop is y and the outermost is z. A start pulse captures the three extents and places the walk on its first element. Each advance strobe then moves it on by one element. For every element the block shows the x, y and z indices and a linear element number. It also shows a 4-bit end-point field that marks which loops finish on that element.

The field is meant for code that runs a matrix or transform schedule. Such code branches on loop boundaries and so needs one flag per level, not a single terminal count. After the last element, one more advance returns the block to an idle state. In that state all indices and flags are zero. The walk stays idle until the next start.

Top module: `nest_loop_flags`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block becomes idle: `active` is 0, and all indices, `elem_idx` and `end_flags` are 0.
- R2: A `start` pulse captures `ext_x`, `ext_y` and `ext_z`, with an extent of 0 treated as 1. From the next cycle, `active` is 1 and all indices and `elem_idx` are 0.
- R3: An `advance` while active increments `idx_x`. When `idx_x` is at extent-1 it wraps to 0 and carries into `idx_y`, and `idx_y` carries into `idx_z` in the same way. While active, every index stays below its extent.
- R4: `elem_idx` equals the number of advances since the start, which is z*ex*ey + y*ex + x.
- R5: `end_flags` bit 0 (innermost end) is 1 exactly when the block is active and `idx_x` equals its extent-1.
- R6: `end_flags` bit 1 (middle end) is 1 exactly when bit 0 is 1 and `idx_y` equals its extent-1.
- R7: `end_flags` bit 2 (outer end) is 1 exactly when bit 1 is 1 and `idx_z` equals its extent-1. Bit 3 (final element) is 1 only on the last element of the walk, where all three loops are at their maximum.
- R8: An advance on the final element makes the block idle, with indices, `elem_idx` and flags all 0. An advance while idle changes nothing.
- R9: Without `start` or `advance` the outputs hold. Changes on the extent inputs after a start do not affect the walk in progress.
- R10: A `start` during a walk restarts it from element 0 with the new extents, and `start` takes priority over an `advance` in the same cycle.
- R11: A loop of extent 1 ends on every element it contains. Its flag is set each time all loops inside it are at their last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture extents and begin a walk |
| advance | input | 1 | Move to the next element |
| ext_x | input | DIM_W | Innermost loop extent |
| ext_y | input | DIM_W | Middle loop extent |
| ext_z | input | DIM_W | Outermost loop extent |
| idx_x | output | DIM_W | Current innermost index |
| idx_y | output | DIM_W | Current middle index |
| idx_z | output | DIM_W | Current outermost index |
| elem_idx | output | 3*DIM_W | Linear element number |
| active | output | 1 | A walk is in progress |
| end_flags | output | 4 | {final, outer end, middle end, inner end} |

## Verification
The assertions assume that `start` and `advance` are clean single-cycle controls. They also assume the captured extents are stable for the whole walk, so each index is checked against the captured limit and not against the live inputs. The stimulus changes extent inputs only around a start pulse, or deliberately in the middle of a walk to show they are ignored. It uses extents that fit in `DIM_W` bits, including 0 and 1. Every walk is driven through to its end so that the final-element wrap is covered for each shape.

// File: rtl/nlf_pkg.sv
// Package: shared constants for the nested loop flag generator.
// Assumes exactly three loop levels; flag bit positions are fixed here.
package nlf_pkg;
    localparam int NLEV     = 3;
    localparam int FLG_W    = 4;
    localparam int FLG_X    = 0;
    localparam int FLG_Y    = 1;
    localparam int FLG_Z    = 2;
    localparam int FLG_LAST = 3;
    typedef logic [FLG_W-1:0] flags_t;
endpackage

// File: rtl/nlf_loop_level.sv
// One loop counter level: counts 0..limit-1 on each step, wraps to zero.
// Assumes limit >= 1; at_last reports the final value for carry and flags.
module nlf_loop_level #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] idx,
    output logic         at_last
);
    // Final value of this level for the captured limit.
    always_comb at_last = (idx == limit - W'(1));

    // Index register: cleared on start, stepped by the carry from inside.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx <= '0;
        else if (clear)  idx <= '0;
        else if (step)   idx <= at_last ? '0 : idx + W'(1);
    end
endmodule

// File: rtl/nlf_flag_encode.sv
// Builds the end-point field from each level's at_last and the active state.
// A level's flag needs all inner levels to be at their last value as well.
module nlf_flag_encode
    import nlf_pkg::*;
(
    input  logic           active,
    input  logic [NLEV-1:0] last,
    output flags_t          flags
);
    logic [NLEV-1:0] chain;

    // Ripple of "this level and every inner level finish here".
    generate
        for (genvar i = 0; i < NLEV; i++) begin : g_chain
            if (i == 0) begin : g_first
                always_comb chain[i] = active & last[i];
            end else begin : g_rest
                always_comb chain[i] = chain[i-1] & last[i];
            end
        end
    endgenerate

    // Field assembly: the final element is where the outermost chain completes.
    always_comb begin
        flags           = '0;
        flags[FLG_X]    = chain[0];
        flags[FLG_Y]    = chain[1];
        flags[FLG_Z]    = chain[2];
        flags[FLG_LAST] = chain[NLEV-1];
    end
endmodule

// File: rtl/nest_loop_flags.sv
// Top: walks x (inner), y, z (outer) loops, one element per advance.
// Captures extents on start (0 treated as 1); returns idle after the last element.
module nest_loop_flags
    import nlf_pkg::*;
#(
    parameter int DIM_W = 4,
    localparam int LIN_W = NLEV * DIM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             advance,
    input  logic [DIM_W-1:0] ext_x,
    input  logic [DIM_W-1:0] ext_y,
    input  logic [DIM_W-1:0] ext_z,
    output logic [DIM_W-1:0] idx_x,
    output logic [DIM_W-1:0] idx_y,
    output logic [DIM_W-1:0] idx_z,
    output logic [LIN_W-1:0] elem_idx,
    output logic             active,
    output logic [FLG_W-1:0] end_flags
);
    logic [DIM_W-1:0] ext_in [NLEV];
    logic [DIM_W-1:0] lim_q  [NLEV];
    logic [DIM_W-1:0] idx    [NLEV];
    logic [NLEV-1:0]  last;
    logic [NLEV:0]    carry;
    flags_t           flags;
    logic             final_elem;

    // Gather extent inputs into an array for the generate loop.
    always_comb begin
        ext_in[0] = ext_x;
        ext_in[1] = ext_y;
        ext_in[2] = ext_z;
    end

    // Carry chain: an accepted advance ripples outward through finishing levels.
    always_comb begin
        carry[0] = advance & active & ~start;
        for (int i = 0; i < NLEV; i++) carry[i+1] = carry[i] & last[i];
    end

    generate
        for (genvar i = 0; i < NLEV; i++) begin : g_lvl
            // Extent capture at start, with zero promoted to one.
            always_ff @(posedge clk) begin
                if (!rst_n)     lim_q[i] <= DIM_W'(1);
                else if (start) lim_q[i] <= (ext_in[i] == '0) ? DIM_W'(1) : ext_in[i];
            end

            nlf_loop_level #(.W(DIM_W)) u_lvl (
                .clk     (clk),
                .rst_n   (rst_n),
                .clear   (start),
                .step    (carry[i]),
                .limit   (lim_q[i]),
                .idx     (idx[i]),
                .at_last (last[i])
            );
        end
    endgenerate

    nlf_flag_encode u_flags (
        .active (active),
        .last   (last),
        .flags  (flags)
    );

    always_comb final_elem = flags[FLG_LAST];

    // Walk state: set by start, cleared by the advance off the final element.
    always_ff @(posedge clk) begin
        if (!rst_n)                      active <= 1'b0;
        else if (start)                  active <= 1'b1;
        else if (carry[0] && final_elem) active <= 1'b0;
    end

    // Linear element counter, kept alongside the indices.
    always_ff @(posedge clk) begin
        if (!rst_n)        elem_idx <= '0;
        else if (start)    elem_idx <= '0;
        else if (carry[0]) elem_idx <= final_elem ? '0 : elem_idx + LIN_W'(1);
    end

    // Output mapping.
    always_comb begin
        idx_x     = idx[0];
        idx_y     = idx[1];
        idx_z     = idx[2];
        end_flags = flags;
    end
endmodule

// File: rtl/nest_loop_flags_chk.sv
// Checker for nest_loop_flags, bound below. Assumes single-cycle start/advance
// and compares indices against the captured limits, not the live inputs.
module nest_loop_flags_chk #(
    parameter int DIM_W = 4,
    localparam int LIN_W = 3 * DIM_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             advance,
    input logic [DIM_W-1:0] idx_x,
    input logic [DIM_W-1:0] idx_y,
    input logic [DIM_W-1:0] idx_z,
    input logic [LIN_W-1:0] elem_idx,
    input logic             active,
    input logic [3:0]       end_flags,
    input logic [DIM_W-1:0] lim_x,
    input logic [DIM_W-1:0] lim_y,
    input logic [DIM_W-1:0] lim_z
);
    assert_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx_x < lim_x) && (idx_y < lim_y) && (idx_z < lim_z));

    assert_start_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> active && elem_idx == '0 && idx_x == '0 && idx_y == '0 && idx_z == '0);

    assert_count_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && advance && !start && !end_flags[3]) |=> elem_idx == $past(elem_idx) + LIN_W'(1));

    assert_mid_nest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        end_flags[1] |-> end_flags[0]);

    assert_outer_nest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        end_flags[2] |-> end_flags[1]);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> end_flags == 4'b0 && elem_idx == '0 && idx_x == '0 && idx_y == '0 && idx_z == '0);

    assert_final_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && advance && !start && end_flags[3]) |=> !active);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !advance) |=> $stable(idx_x) && $stable(idx_y) && $stable(idx_z) && $stable(elem_idx));
endmodule

bind nest_loop_flags nest_loop_flags_chk #(.DIM_W(DIM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .advance   (advance),
    .idx_x     (idx_x),
    .idx_y     (idx_y),
    .idx_z     (idx_z),
    .elem_idx  (elem_idx),
    .active    (active),
    .end_flags (end_flags),
    .lim_x     (lim_q[0]),
    .lim_y     (lim_q[1]),
    .lim_z     (lim_q[2])
);

// File: tb/nest_loop_flags_test.sv
// Bench: table of loop shapes walked to completion, then directed corner tests.
module nest_loop_flags_test;
    localparam int W  = 4;
    localparam int LW = 3 * W;
    localparam int NCFG = 7;
    localparam int CFG [NCFG][3] = '{
        '{3, 2, 2}, '{1, 4, 1}, '{2, 1, 3}, '{1, 1, 1},
        '{4, 3, 2}, '{5, 7, 3}, '{0, 2, 0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          advance = 1'b0;
    logic [W-1:0]  ext_x = '0, ext_y = '0, ext_z = '0;
    logic [W-1:0]  idx_x, idx_y, idx_z;
    logic [LW-1:0] elem_idx;
    logic          active;
    logic [3:0]    end_flags;
    int            n_run = 0;
    int            n_fail = 0;

    always #5 clk = ~clk;

    nest_loop_flags #(.DIM_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
        .ext_x(ext_x), .ext_y(ext_y), .ext_z(ext_z),
        .idx_x(idx_x), .idx_y(idx_y), .idx_z(idx_z),
        .elem_idx(elem_idx), .active(active), .end_flags(end_flags)
    );

    function automatic logic [63:0] pack(int x, int y, int z, int e, bit a, logic [3:0] f);
        return 64'({W'(x), W'(y), W'(z), LW'(e), a, f});
    endfunction

    task automatic chk(string req, logic [63:0] exp);
        logic [63:0] act;
        act = pack(idx_x, idx_y, idx_z, elem_idx, active, end_flags);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_start(int ex, int ey, int ez);
        @(negedge clk);
        ext_x = W'(ex); ext_y = W'(ey); ext_z = W'(ez); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_step();
        @(negedge clk);
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
    endtask

    // Expected outputs for element e of a shape, from the requirement formulas.
    function automatic logic [63:0] model(int ex, int ey, int ez, int e);
        int x, y, z;
        logic [3:0] f;
        x = e % ex; y = (e / ex) % ey; z = e / (ex * ey);
        f[0] = (x == ex - 1);
        f[1] = f[0] && (y == ey - 1);
        f[2] = f[1] && (z == ez - 1);
        f[3] = f[2];
        return pack(x, y, z, e, 1'b1, f);
    endfunction

    task automatic walk(int ex_in, int ey_in, int ez_in);
        int ex, ey, ez;
        ex = (ex_in == 0) ? 1 : ex_in;
        ey = (ey_in == 0) ? 1 : ey_in;
        ez = (ez_in == 0) ? 1 : ez_in;
        do_start(ex_in, ey_in, ez_in);
        for (int e = 0; e < ex * ey * ez; e++) begin
            chk("R2 R3 R4 R5 R6 R7 R11 element", model(ex, ey, ez, e));
            do_step();
        end
        chk("R8 after final element", pack(0, 0, 0, 0, 1'b0, 4'b0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 reset", pack(0, 0, 0, 0, 1'b0, 4'b0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset release", pack(0, 0, 0, 0, 1'b0, 4'b0));

        // Table-driven full walks (includes zero extents for R2)
        for (int i = 0; i < NCFG; i++) walk(CFG[i][0], CFG[i][1], CFG[i][2]);

        // R8: advance while idle is ignored
        do_step();
        chk("R8 idle advance", pack(0, 0, 0, 0, 1'b0, 4'b0));

        // R11: middle extent 1 flags with the inner end
        do_start(2, 1, 2);
        do_step();
        chk("R11 unit middle loop", pack(1, 0, 0, 1, 1'b1, 4'b0011));

        // R9: hold without strobes, extent changes mid-walk ignored
        do_start(3, 3, 1);
        do_step();
        ext_x = 1; ext_y = 1; ext_z = 1;
        repeat (3) @(negedge clk);
        chk("R9 hold", pack(1, 0, 0, 1, 1'b1, 4'b0000));
        do_step();
        chk("R9 captured extent", pack(2, 0, 0, 2, 1'b1, 4'b0001));
        do_step();
        chk("R9 carry into y", pack(0, 1, 0, 3, 1'b1, 4'b0000));

        // R10: start with advance in the same cycle restarts at zero
        @(negedge clk);
        ext_x = 2; ext_y = 2; ext_z = 2; start = 1'b1; advance = 1'b1;
        @(negedge clk);
        start = 1'b0; advance = 1'b0;
        chk("R10 restart priority", pack(0, 0, 0, 0, 1'b1, 4'b0000));
        do_step();
        chk("R10 new extents", pack(1, 0, 0, 1, 1'b1, 4'b0001));

        // R1: reset mid-walk
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-walk", pack(0, 0, 0, 0, 1'b0, 4'b0));
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule